// File: doc/BRIEF.md
# Load/Store Port Memory Responder

This block answers a single load/store port with a small byte-addressable memory held inside it. A requester presents an operation kind (load or store), a transfer length of 1, 2, 4 or 8 bytes, a 48-bit address and an address-valid flag, all at the same time. The responder then sequences the transaction through a short handshake. It acknowledges the address, takes store data on a one-cycle strobe or returns load data with a one-cycle valid flag, and keeps `busy_o` high from the first cycle after acceptance until the requester has withdrawn its request.

Each transfer falls into the byte lanes of one 64-bit doubleword. The lanes come from the length and the low three address bits. Byte 0 of the store data goes to the lowest addressed lane, so the memory is little-endian. A load returns the addressed bytes shifted down to bit 0, with zeros above the requested length. The memory holds 64 doublewords.

Top module: `lsport_mem`

## Requirements
- R1: After reset, `busy_o`, `addr_ack_o` and `ld_vld_o` are low and `ld_data_o` is zero.
- R2: While idle, a cycle with `addr_vld_i` high and `ld_req_i` or `st_req_i` high starts a transaction. In the next cycle `busy_o` and `addr_ack_o` are high. When `addr_vld_i` is low, no transaction starts and `busy_o` stays low.
- R3: For a store, `addr_ack_o` stays high until the first cycle in which `st_strobe_i` is high. That may be the first acknowledge cycle or any later cycle. The data on `st_data_i` in that cycle is the data written, and `addr_ack_o` is low in the following cycle.
- R4: A strobe at any other time has no effect on memory. This covers a strobe while idle and a strobe during a load.
- R5: Length encoding on `len_i`: the value 1, 2, 4 or 8 is the byte count. A store writes lanes off to off+len-1 of the doubleword, where off = `addr_i[2:0]`. Lane off+j receives `st_data_i[8j+7:8j]`, and all other lanes keep their contents.
- R6: A store whose lanes would pass lane 7 (off+len > 8) leaves the memory unchanged. So does a store whose length is not 1, 2, 4 or 8.
- R7: For a load, `ld_vld_o` is high for exactly one cycle, the cycle after the single acknowledge cycle. In that cycle `ld_data_o` byte j holds lane off+j for j < len, and is zero when off+j > 7 or j >= len. `ld_data_o` is zero whenever `ld_vld_o` is low.
- R8: After the write or the load-valid cycle, `busy_o` stays high while any of `ld_req_i`, `st_req_i` or `addr_vld_i` is high. It goes low one cycle after all three are low.
- R9: `addr_i[8:3]` selects the doubleword. Address bits 47:9 are ignored.
- R10: Two 2-byte stores at A and A+2, where A is 4-byte aligned, read back by a 4-byte load at A give the first halfword in bits 15:0 and the second in bits 31:16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_req_i | input | 1 | Load requested |
| st_req_i | input | 1 | Store requested |
| len_i | input | 4 | Transfer length in bytes (1, 2, 4, 8) |
| addr_i | input | 48 | Byte address |
| addr_vld_i | input | 1 | Address and request fields are valid |
| st_data_i | input | 64 | Store data, low byte first |
| st_strobe_i | input | 1 | One-cycle store data strobe |
| addr_ack_o | output | 1 | Address has been taken |
| ld_data_o | output | 64 | Load data, zero-extended |
| ld_vld_o | output | 1 | Load data valid for one cycle |
| busy_o | output | 1 | Transaction in progress |

## Verification
The assertions check the handshake shape on every cycle. They confirm that a valid request in idle is answered with busy and acknowledge in the next cycle, and that the acknowledge persists until the store strobe and drops after it. They also confirm that load-valid is a single pulse directly following an acknowledge, that load data is zero outside that pulse, and that busy cannot drop while the requester still holds any request signal. Only the bench scenarios can show which bytes land where. That covers lane selection at every offset, little-endian halfword packing, preservation of neighbouring lanes, rejected boundary-crossing and odd-length stores, address aliasing above bit 8, and strobes that must leave the memory untouched.

// File: rtl/lsport_pkg.sv
package lsport_pkg;
  typedef enum logic [2:0] {
    S_IDLE    = 3'd0,
    S_ACK     = 3'd1,
    S_WAIT_ST = 3'd2,
    S_WRITE   = 3'd3,
    S_LD_VLD  = 3'd4,
    S_DONE    = 3'd5
  } lsp_state_t;
endpackage

// File: rtl/lsport_ctrl.sv
module lsport_ctrl
  import lsport_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ld_req_i,
  input  logic st_req_i,
  input  logic addr_vld_i,
  input  logic st_strobe_i,
  output logic start_o,
  output logic take_st_o,
  output logic rd_take_o,
  output logic wr_en_o,
  output logic ack_o,
  output logic ld_vld_o,
  output logic busy_o
);
  lsp_state_t state_q, state_d;
  logic       is_st_q, is_st_d;
  logic       req_any;

  assign req_any = ld_req_i | st_req_i;

  always_comb begin
    state_d = state_q;
    is_st_d = is_st_q;
    unique case (state_q)
      S_IDLE: begin
        if (addr_vld_i && req_any) begin
          state_d = S_ACK;
          is_st_d = st_req_i;
        end
      end
      S_ACK: begin
        if (is_st_q) state_d = st_strobe_i ? S_WRITE : S_WAIT_ST;
        else         state_d = S_LD_VLD;
      end
      S_WAIT_ST: if (st_strobe_i) state_d = S_WRITE;
      S_WRITE:   state_d = S_DONE;
      S_LD_VLD:  state_d = S_DONE;
      S_DONE:    if (!req_any && !addr_vld_i) state_d = S_IDLE;
      default:   state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      is_st_q <= 1'b0;
    end else begin
      state_q <= state_d;
      is_st_q <= is_st_d;
    end
  end

  assign start_o   = (state_q == S_IDLE) && addr_vld_i && req_any;
  assign ack_o     = (state_q == S_ACK) || (state_q == S_WAIT_ST);
  assign take_st_o = ack_o && is_st_q && st_strobe_i;
  assign rd_take_o = (state_q == S_ACK) && !is_st_q;
  assign wr_en_o   = (state_q == S_WRITE);
  assign ld_vld_o  = (state_q == S_LD_VLD);
  assign busy_o    = (state_q != S_IDLE);
endmodule

// File: rtl/lsport_lanes.sv
module lsport_lanes #(
  parameter int DATA_W = 64,
  parameter int LEN_W  = 4,
  parameter int LANES  = DATA_W / 8,
  parameter int OFF_W  = $clog2(LANES)
) (
  input  logic [LEN_W-1:0]  len_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [LANES-1:0]  wmask_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic                   len_ok;
  logic [LANES-1:0]       run;
  logic [2*LANES-1:0]     span;
  logic [DATA_W-1:0]      shifted;

  always_comb begin
    len_ok = (len_i != '0) && ((len_i & (len_i - 1'b1)) == '0) &&
             (int'(len_i) <= LANES);
    for (int i = 0; i < LANES; i++) run[i] = len_ok && (i < int'(len_i));
    span    = {{LANES{1'b0}}, run} << off_i;
    wmask_o = (span[2*LANES-1:LANES] == '0) ? span[LANES-1:0] : '0;
    wdata_o = wdata_i << {off_i, 3'b000};
    shifted = rdata_i >> {off_i, 3'b000};
    for (int i = 0; i < LANES; i++)
      rdata_o[8*i +: 8] = run[i] ? shifted[8*i +: 8] : 8'h00;
  end
endmodule

// File: rtl/lsport_array.sv
module lsport_array #(
  parameter int DATA_W = 64,
  parameter int IDX_W  = 6,
  parameter int LANES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [LANES-1:0]  mask_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 2 ** IDX_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) begin
      for (int b = 0; b < LANES; b++)
        if (mask_i[b]) mem_q[idx_i][8*b +: 8] <= wdata_i[8*b +: 8];
    end
  end

  assign rdata_o = mem_q[idx_i];
endmodule

// File: rtl/lsport_mem.sv
module lsport_mem #(
  parameter int ADDR_W = 48,
  parameter int DATA_W = 64,
  parameter int IDX_W  = 6,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_req_i,
  input  logic              st_req_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              addr_vld_i,
  input  logic [DATA_W-1:0] st_data_i,
  input  logic              st_strobe_i,
  output logic              addr_ack_o,
  output logic [DATA_W-1:0] ld_data_o,
  output logic              ld_vld_o,
  output logic              busy_o
);
  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = $clog2(LANES);

  logic              start, take_st, rd_take, wr_en;
  logic [IDX_W-1:0]  idx_q;
  logic [OFF_W-1:0]  off_q;
  logic [LEN_W-1:0]  len_q;
  logic [DATA_W-1:0] st_data_q, ld_data_q;
  logic [LANES-1:0]  wmask;
  logic [DATA_W-1:0] wdata_al, rdata_raw, rdata_al;
  logic              addr_hi_unused;

  assign addr_hi_unused = ^addr_i[ADDR_W-1:OFF_W+IDX_W];

  lsport_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .ld_req_i    (ld_req_i),
    .st_req_i    (st_req_i),
    .addr_vld_i  (addr_vld_i),
    .st_strobe_i (st_strobe_i),
    .start_o     (start),
    .take_st_o   (take_st),
    .rd_take_o   (rd_take),
    .wr_en_o     (wr_en),
    .ack_o       (addr_ack_o),
    .ld_vld_o    (ld_vld_o),
    .busy_o      (busy_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      off_q <= '0;
      len_q <= '0;
    end else if (start) begin
      idx_q <= addr_i[OFF_W +: IDX_W];
      off_q <= addr_i[OFF_W-1:0];
      len_q <= len_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       st_data_q <= '0;
    else if (take_st) st_data_q <= st_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ld_data_q <= '0;
    else if (rd_take) ld_data_q <= rdata_al;
  end

  lsport_lanes #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_lanes (
    .len_i   (len_q),
    .off_i   (off_q),
    .wdata_i (st_data_q),
    .rdata_i (rdata_raw),
    .wmask_o (wmask),
    .wdata_o (wdata_al),
    .rdata_o (rdata_al)
  );

  lsport_array #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_array (
    .clk     (clk),
    .we_i    (wr_en),
    .idx_i   (idx_q),
    .mask_i  (wmask),
    .wdata_i (wdata_al),
    .rdata_o (rdata_raw)
  );

  assign ld_data_o = ld_vld_o ? ld_data_q : '0;
endmodule

// File: rtl/lsport_mem_chk.sv
module lsport_mem_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ld_req_i,
  input logic              st_req_i,
  input logic              addr_vld_i,
  input logic              st_strobe_i,
  input logic              addr_ack_o,
  input logic              ld_vld_o,
  input logic              busy_o,
  input logic [DATA_W-1:0] ld_data_o
);
  // R2
  start_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && addr_vld_i && (ld_req_i || st_req_i)) |=> (busy_o && addr_ack_o));

  // R2
  idle_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !addr_vld_i) |=> !busy_o);

  // R3
  ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_ack_o && st_req_i && !st_strobe_i) |=> addr_ack_o);

  // R3
  ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_ack_o && st_req_i && st_strobe_i) |=> !addr_ack_o);

  // R7
  ld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_vld_o |=> !ld_vld_o);

  // R7
  ld_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ld_vld_o) |-> $past(addr_ack_o));

  // R7
  ld_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_vld_o |-> (ld_data_o == '0));

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !addr_ack_o && !ld_vld_o && (ld_req_i || st_req_i || addr_vld_i))
      |=> busy_o);
endmodule

bind lsport_mem lsport_mem_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ld_req_i    (ld_req_i),
  .st_req_i    (st_req_i),
  .addr_vld_i  (addr_vld_i),
  .st_strobe_i (st_strobe_i),
  .addr_ack_o  (addr_ack_o),
  .ld_vld_o    (ld_vld_o),
  .busy_o      (busy_o),
  .ld_data_o   (ld_data_o)
);

// File: tb/lsport_mem_bench.sv
`timescale 1ns/1ps
module lsport_mem_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_req_i = 1'b0, st_req_i = 1'b0, addr_vld_i = 1'b0, st_strobe_i = 1'b0;
  logic [3:0]  len_i = '0;
  logic [47:0] addr_i = '0;
  logic [63:0] st_data_i = '0;
  logic        addr_ack_o, ld_vld_o, busy_o;
  logic [63:0] ld_data_o;

  int nvec = 0;
  int nfail = 0;
  bit finished = 1'b0;
  logic [7:0] mm [512];

  always #4 clk = ~clk;

  lsport_mem u_lsport_mem (
    .clk(clk), .rst_n(rst_n), .ld_req_i(ld_req_i), .st_req_i(st_req_i),
    .len_i(len_i), .addr_i(addr_i), .addr_vld_i(addr_vld_i),
    .st_data_i(st_data_i), .st_strobe_i(st_strobe_i), .addr_ack_o(addr_ack_o),
    .ld_data_o(ld_data_o), .ld_vld_o(ld_vld_o), .busy_o(busy_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit len_ok(input logic [3:0] n);
    return (n == 4'd1) || (n == 4'd2) || (n == 4'd4) || (n == 4'd8);
  endfunction

  function automatic logic [63:0] model_load(input logic [47:0] a, input logic [3:0] n);
    logic [63:0] r;
    int off;
    r = '0;
    off = int'(a[2:0]);
    if (len_ok(n))
      for (int j = 0; j < int'(n); j++)
        if (off + j < 8) r[8*j +: 8] = mm[{a[8:3], 3'(off + j)}];
    return r;
  endfunction

  task automatic model_store(input logic [47:0] a, input logic [3:0] n, input logic [63:0] d);
    int off;
    off = int'(a[2:0]);
    if (len_ok(n) && (off + int'(n) <= 8))
      for (int j = 0; j < int'(n); j++) mm[{a[8:3], 3'(off + j)}] = d[8*j +: 8];
  endtask

  task automatic do_store(input logic [47:0] a, input logic [3:0] n, input logic [63:0] d,
                          input int dly, input int hold);
    @(negedge clk);
    chk("R2 busy before start", 64'(busy_o), 64'd0);
    st_req_i = 1'b1; len_i = n; addr_i = a; addr_vld_i = 1'b1;
    @(negedge clk);
    chk("R2 busy after start", 64'(busy_o), 64'd1);
    chk("R2 ack after start", 64'(addr_ack_o), 64'd1);
    chk("R7 no ld_vld on store", 64'(ld_vld_o), 64'd0);
    for (int k = 0; k < dly; k++) begin
      @(negedge clk);
      chk("R3 ack held until strobe", 64'(addr_ack_o), 64'd1);
    end
    st_strobe_i = 1'b1; st_data_i = d;
    @(negedge clk);
    st_strobe_i = 1'b0; st_data_i = ~d;
    chk("R3 ack low after strobe", 64'(addr_ack_o), 64'd0);
    chk("R8 busy during write", 64'(busy_o), 64'd1);
    model_store(a, n, d);
    @(negedge clk);
    chk("R8 busy after write", 64'(busy_o), 64'd1);
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk("R8 busy while request held", 64'(busy_o), 64'd1);
    end
    st_req_i = 1'b0; addr_vld_i = 1'b0;
    @(negedge clk);
    chk("R8 idle after drop", 64'(busy_o), 64'd0);
  endtask

  task automatic do_load(input logic [47:0] a, input logic [3:0] n, input int hold,
                         input bit noise, input string req);
    logic [63:0] exp;
    exp = model_load(a, n);
    @(negedge clk);
    chk("R2 busy before start", 64'(busy_o), 64'd0);
    ld_req_i = 1'b1; len_i = n; addr_i = a; addr_vld_i = 1'b1;
    @(negedge clk);
    chk("R2 ack on load", 64'(addr_ack_o), 64'd1);
    chk("R7 ld_vld low in ack", 64'(ld_vld_o), 64'd0);
    chk("R7 ld_data zero in ack", ld_data_o, 64'd0);
    if (noise) begin st_strobe_i = 1'b1; st_data_i = 64'hA5A5_A5A5_A5A5_A5A5; end
    @(negedge clk);
    st_strobe_i = 1'b0;
    chk("R7 ld_vld", 64'(ld_vld_o), 64'd1);
    chk(req, ld_data_o, exp);
    chk("R7 ack low in load valid", 64'(addr_ack_o), 64'd0);
    @(negedge clk);
    chk("R7 ld_vld single cycle", 64'(ld_vld_o), 64'd0);
    chk("R8 busy after load", 64'(busy_o), 64'd1);
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk("R8 busy while load held", 64'(busy_o), 64'd1);
    end
    ld_req_i = 1'b0; addr_vld_i = 1'b0;
    @(negedge clk);
    chk("R8 idle after load drop", 64'(busy_o), 64'd0);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL R8 watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy at reset", 64'(busy_o), 64'd0);
    chk("R1 ack at reset", 64'(addr_ack_o), 64'd0);
    chk("R1 ld_vld at reset", 64'(ld_vld_o), 64'd0);
    chk("R1 ld_data at reset", ld_data_o, 64'd0);
    rst_n = 1'b1;

    // R2: request without address-valid does not start
    @(negedge clk);
    ld_req_i = 1'b1; st_req_i = 1'b1; addr_i = 48'h8;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R2 no start without addr_vld", 64'(busy_o), 64'd0);
    end
    ld_req_i = 1'b0; st_req_i = 1'b0;

    // fill all doublewords with zero
    for (int i = 0; i < 64; i++) do_store(48'(i * 8), 4'd8, 64'd0, 0, 0);

    // R10: halfword pair, little-endian
    do_store(48'h4, 4'd2, 64'hBEEF, 0, 0);
    do_store(48'h6, 4'd2, 64'hF00F, 0, 0);
    do_load(48'h4, 4'd2, 0, 1'b0, "R10 first halfword");
    do_load(48'h6, 4'd2, 0, 1'b0, "R10 second halfword");
    do_load(48'h4, 4'd4, 0, 1'b0, "R10 word 0xF00FBEEF");
    chk("R10 literal", model_load(48'h4, 4'd4), 64'h0000_0000_F00F_BEEF);

    // R5: byte lanes at each offset, strobe delayed
    for (int o = 0; o < 8; o++) do_store(48'h40 + 48'(o), 4'd1, 64'(8'h10 + o), o % 3, 0);
    do_load(48'h40, 4'd8, 0, 1'b0, "R5 byte lanes");
    do_store(48'h44, 4'd4, 64'hFFEE_DDCC_1122_3344, 3, 0);
    do_load(48'h40, 4'd8, 0, 1'b0, "R5 word lanes keep neighbours");
    do_store(48'h52, 4'd2, 64'h1234_9876, 1, 0);
    do_load(48'h50, 4'd8, 0, 1'b0, "R5 halfword lanes");
    do_load(48'h45, 4'd2, 0, 1'b0, "R7 unaligned halfword load");
    do_load(48'h46, 4'd4, 0, 1'b0, "R7 crossing load zero-extended");

    // R6: crossing and odd length stores leave memory unchanged
    do_store(48'h86, 4'd4, 64'hDEAD_BEEF, 0, 0);
    do_store(48'h88, 4'd3, 64'hCAFE_BABE, 0, 0);
    do_load(48'h80, 4'd8, 0, 1'b0, "R6 crossing store ignored");
    do_load(48'h88, 4'd8, 0, 1'b0, "R6 odd length ignored");
    do_load(48'h88, 4'd3, 0, 1'b0, "R7 odd length load zero");

    // R9: high address bits ignored
    do_store(48'hABC0_0000_0110, 4'd8, 64'h0123_4567_89AB_CDEF, 0, 0);
    do_load(48'h0000_0000_0110, 4'd8, 0, 1'b0, "R9 alias low");
    do_load(48'h7000_0000_0114, 4'd4, 0, 1'b0, "R9 alias high");

    // R4: strobes outside a store window
    @(negedge clk);
    st_strobe_i = 1'b1; st_data_i = '1;
    @(negedge clk);
    st_strobe_i = 1'b0;
    chk("R4 idle strobe no busy", 64'(busy_o), 64'd0);
    do_load(48'h110, 4'd8, 0, 1'b1, "R4 strobe during load");
    do_load(48'h110, 4'd8, 0, 1'b0, "R4 memory unchanged");

    // R8: holding the request keeps busy high
    do_store(48'h1F8, 4'd8, 64'h5555_6666_7777_8888, 0, 3);
    do_load(48'h1F8, 4'd8, 4, 1'b0, "R8 load after held store");

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule